// File: doc/BRIEF.md
# Regulator Standby and Wake Controller

This block is the mode sequencer of a supply regulator that shares a die with a single-wire bus transceiver. It takes digital flags from the analog front end: battery sense above its upper threshold, the enable pin level, the received bus level, an over-temperature trip, a temperature-recovered flag and a flag that the regulated supply is above the low reset level. From these flags it drives the regulator enable, the bus driver enable, the strength of the enable pin pull-down and a one-cycle request to the reset generator.

The block has five states. `MS_OFF` means no battery. `MS_RESTART` lasts one cycle, with the regulator on and a reset requested. `MS_ACTIVE` means running. `MS_STANDBY` means the regulator is off. `MS_THERMAL` means everything is shut down for heat.

The transitions are as follows:
- power-up (`MS_OFF`→`MS_RESTART`)
- settle (`MS_RESTART`→`MS_ACTIVE`)
- disable (`MS_ACTIVE`→`MS_STANDBY`)
- enable wake (`MS_STANDBY`→`MS_ACTIVE`)
- bus wake (`MS_STANDBY`→`MS_ACTIVE`)
- thermal trip (`MS_ACTIVE`, `MS_RESTART` or `MS_STANDBY` → `MS_THERMAL`)
- thermal recovery (`MS_THERMAL`→`MS_RESTART`)
- battery loss (any state → `MS_OFF`)

A tick-counted filter watches the bus while the block is in standby. It only allows a wake when the bus has held a changed level for a full qualifying window.

Top module: `regwake_ctrl`

## Requirements
- R1: While reset is applied, and afterwards while battery sense stays low, the block sits in `MS_OFF`. Its outputs are then reg_on=0, bus_drv_en=0, en_pd_strong=1 and rst_req=0.
- R2: When battery sense goes high in `MS_OFF`, the block spends exactly one cycle in `MS_RESTART` with reg_on=1 and rst_req=1, then enters `MS_ACTIVE`. It does this whatever the enable pin level is.
- R3: In `MS_ACTIVE`, a low enable pin has no effect until the enable pin has been high during the current stay in `MS_ACTIVE`. This applies after power-up, after a restart and after a bus wake.
- R4: Once the enable pin has been high in `MS_ACTIVE`, a low enable pin moves the block to `MS_STANDBY` at the next edge, and reg_on becomes 0.
- R5: en_pd_strong is 1 (strong pull-down) in `MS_OFF`, `MS_STANDBY` and `MS_THERMAL`. It is 0 (weak pull-down) in `MS_RESTART` and `MS_ACTIVE`.
- R6: In `MS_STANDBY`, a high enable pin returns the block to `MS_ACTIVE` at the next edge.
- R7: The bus reference level is captured on the last cycle before standby. In `MS_STANDBY`, the bus wakes the block only after it has differed from that reference for WAKE_TICKS tick cycles in a row. A return to the reference level restarts the count from zero, so shorter glitches are ignored.
- R8: An over-temperature trip in `MS_RESTART`, `MS_ACTIVE` or `MS_STANDBY` moves the block to `MS_THERMAL`. In that state reg_on=0 and bus_drv_en=0.
- R9: In `MS_THERMAL`, the recovered flag moves the block to `MS_RESTART`, which produces a reset request, whatever the enable and bus levels are. Until that flag is set, neither the enable pin nor the bus has any effect.
- R10: bus_drv_en is 1 only when the regulator is on and the supply-above-low-reset flag is 1. It falls in the same cycle that flag falls.
- R11: Loss of battery sense moves the block to `MS_OFF` at the next edge from every state. This takes priority over every other input.
- R12: When an over-temperature trip arrives in the same cycle as an enable wake, a qualified bus wake or a standby request, the trip wins and the block enters `MS_THERMAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe for the wake filter |
| batt_ok | input | 1 | Battery sense above upper threshold |
| en_pin | input | 1 | Enable pin level |
| bus_rx | input | 1 | Received bus level |
| ot_trip | input | 1 | Over-temperature trip flag |
| ot_recovered | input | 1 | Temperature back in normal range |
| vcc_above_low | input | 1 | Regulated supply above the low reset level |
| reg_on | output | 1 | Regulator enable |
| bus_drv_en | output | 1 | Bus driver enable (0 = high impedance) |
| en_pd_strong | output | 1 | Enable pin pull-down strength (1 = strong, 0 = weak) |
| rst_req | output | 1 | Request to the reset generator |

## Verification
The interesting coincidence is a thermal trip arriving in the same cycle as a standby exit. The exit may come either from the enable pin or from the wake filter reaching its full count. The bench holds a changed bus level in standby and raises the trip exactly on the cycle the filter qualifies. It also raises the trip together with the enable pin, and separately together with an armed standby request. A behavioural model, updated on every edge, predicts `MS_THERMAL` as the result, and the bench also checks in each case that reg_on and bus_drv_en are low.

// File: rtl/regwake_pkg.sv
package regwake_pkg;

    typedef enum logic [2:0] {
        MS_OFF     = 3'd0,
        MS_RESTART = 3'd1,
        MS_ACTIVE  = 3'd2,
        MS_STANDBY = 3'd3,
        MS_THERMAL = 3'd4
    } mode_e;

    typedef struct packed {
        logic reg_on;
        logic bus_drv;
        logic pd_strong;
        logic rst_req;
    } mode_out_t;

endpackage

// File: rtl/rw_wake_filter.sv
module rw_wake_filter #(
    parameter int WAKE_TICKS = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic tick_i,
    input  logic bus_i,
    output logic wake_o
);
    localparam int CNT_W = $clog2(WAKE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAKE_TICKS);

    logic             ref_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differs;

    assign differs = (bus_i != ref_q);

    // Reference level follows the bus while not in standby, frozen inside it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= 1'b1;
        end else if (!enable_i) begin
            ref_q <= bus_i;
        end
    end

    // Duration counter: restarts on any revert to the reference level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable_i || !differs) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q < CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wake_o = enable_i && (cnt_q == CNT_MAX);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    p_revert_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !differs) |=> (cnt_q == '0));

    p_idle_no_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !wake_o);

endmodule

// File: rtl/rw_en_arm.sv
module rw_en_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic en_i,
    output logic armed_o
);
    logic armed_q;

    // Armed only by a high enable seen during the current stay in active.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!active_i) begin
            armed_q <= 1'b0;
        end else if (en_i) begin
            armed_q <= 1'b1;
        end
    end

    assign armed_o = armed_q;

    p_arm_needs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(en_i));

endmodule

// File: rtl/rw_mode_fsm.sv
module rw_mode_fsm
    import regwake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      batt_ok_i,
    input  logic      en_i,
    input  logic      armed_i,
    input  logic      wake_i,
    input  logic      ot_trip_i,
    input  logic      ot_rec_i,
    input  logic      vcc_ok_i,
    output mode_e     state_o,
    output mode_out_t outs_o
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_OFF: begin
                if (batt_ok_i) state_d = MS_RESTART;
            end
            MS_RESTART: begin
                if (!batt_ok_i)     state_d = MS_OFF;
                else if (ot_trip_i) state_d = MS_THERMAL;
                else                state_d = MS_ACTIVE;
            end
            MS_ACTIVE: begin
                if (!batt_ok_i)             state_d = MS_OFF;
                else if (ot_trip_i)         state_d = MS_THERMAL;
                else if (armed_i && !en_i)  state_d = MS_STANDBY;
            end
            MS_STANDBY: begin
                if (!batt_ok_i)          state_d = MS_OFF;
                else if (ot_trip_i)      state_d = MS_THERMAL;
                else if (en_i || wake_i) state_d = MS_ACTIVE;
            end
            MS_THERMAL: begin
                if (!batt_ok_i)     state_d = MS_OFF;
                else if (ot_rec_i)  state_d = MS_RESTART;
            end
            default: state_d = MS_OFF;
        endcase
    end

    always_comb begin
        outs_o = '{reg_on: 1'b0, bus_drv: 1'b0, pd_strong: 1'b1, rst_req: 1'b0};
        unique case (state_q)
            MS_RESTART: begin
                outs_o.reg_on    = 1'b1;
                outs_o.bus_drv   = vcc_ok_i;
                outs_o.pd_strong = 1'b0;
                outs_o.rst_req   = 1'b1;
            end
            MS_ACTIVE: begin
                outs_o.reg_on    = 1'b1;
                outs_o.bus_drv   = vcc_ok_i;
                outs_o.pd_strong = 1'b0;
            end
            MS_OFF, MS_STANDBY, MS_THERMAL: begin
                outs_o.pd_strong = 1'b1;
            end
            default: begin
                outs_o.pd_strong = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

    p_restart_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_RESTART) |=> (state_q != MS_RESTART));

    p_no_early_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_ACTIVE && !armed_i && batt_ok_i && !ot_trip_i)
            |=> (state_q == MS_ACTIVE));

    p_thermal_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_THERMAL) |-> (!outs_o.reg_on && !outs_o.bus_drv));

    p_bus_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok_i |-> !outs_o.bus_drv);

    p_batt_loss_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_ok_i |=> (state_q == MS_OFF));

    p_trip_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_STANDBY && batt_ok_i && ot_trip_i) |=> (state_q == MS_THERMAL));

endmodule

// File: rtl/regwake_ctrl.sv
module regwake_ctrl #(
    parameter int WAKE_TICKS = 45
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_ok,
    input  logic en_pin,
    input  logic bus_rx,
    input  logic ot_trip,
    input  logic ot_recovered,
    input  logic vcc_above_low,
    output logic reg_on,
    output logic bus_drv_en,
    output logic en_pd_strong,
    output logic rst_req
);
    import regwake_pkg::*;

    mode_e     state;
    mode_out_t outs;
    logic      armed;
    logic      wake;
    logic      in_standby;
    logic      in_active;

    assign in_standby = (state == MS_STANDBY);
    assign in_active  = (state == MS_ACTIVE);

    rw_wake_filter #(.WAKE_TICKS(WAKE_TICKS)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (in_standby),
        .tick_i   (tick),
        .bus_i    (bus_rx),
        .wake_o   (wake)
    );

    rw_en_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (in_active),
        .en_i     (en_pin),
        .armed_o  (armed)
    );

    rw_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .batt_ok_i (batt_ok),
        .en_i      (en_pin),
        .armed_i   (armed),
        .wake_i    (wake),
        .ot_trip_i (ot_trip),
        .ot_rec_i  (ot_recovered),
        .vcc_ok_i  (vcc_above_low),
        .state_o   (state),
        .outs_o    (outs)
    );

    assign reg_on       = outs.reg_on;
    assign bus_drv_en   = outs.bus_drv;
    assign en_pd_strong = outs.pd_strong;
    assign rst_req      = outs.rst_req;

    p_pd_weak_when_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_on |-> !en_pd_strong);

endmodule

// File: tb/test_regwake_ctrl.sv
`timescale 1ns/1ps
module test_regwake_ctrl;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic batt_ok = 1'b0, en_pin = 1'b0, bus_rx = 1'b1;
    logic ot_trip = 1'b0, ot_recovered = 1'b0, vcc_above_low = 1'b1;
    logic reg_on, bus_drv_en, en_pd_strong, rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    regwake_ctrl #(.WAKE_TICKS(N)) i_regwake_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .batt_ok(batt_ok),
        .en_pin(en_pin), .bus_rx(bus_rx), .ot_trip(ot_trip),
        .ot_recovered(ot_recovered), .vcc_above_low(vcc_above_low),
        .reg_on(reg_on), .bus_drv_en(bus_drv_en),
        .en_pd_strong(en_pd_strong), .rst_req(rst_req)
    );

    // Tick every third cycle.
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 3;
            tick = (tc == 0);
        end
    end

    // Behavioural model: 0 off, 1 restart, 2 active, 3 standby, 4 thermal.
    int m_st = 0;
    int m_cnt = 0;
    bit m_arm = 0;
    bit m_ref = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_arm = 0; m_ref = 1;
        end else begin
            int nx;
            bit wk;
            wk = (m_st == 3) && (m_cnt == N);
            nx = m_st;
            if (m_st == 0) begin
                if (batt_ok) nx = 1;
            end else if (!batt_ok) nx = 0;
            else if (m_st == 4) begin
                if (ot_recovered) nx = 1;
            end else if (ot_trip) nx = 4;
            else if (m_st == 1) nx = 2;
            else if (m_st == 2) begin
                if (m_arm && !en_pin) nx = 3;
            end else if (m_st == 3) begin
                if (en_pin || wk) nx = 2;
            end
            if (m_st != 3) begin
                m_cnt = 0; m_ref = bus_rx;
            end else if (bus_rx == m_ref) m_cnt = 0;
            else if (tick && m_cnt < N) m_cnt++;
            if (m_st != 2) m_arm = 0;
            else if (en_pin) m_arm = 1;
            m_st = nx;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Compare every cycle against the model.
    always @(negedge clk) begin
        if (!done) begin
            logic on_e;
            on_e = (m_st == 1 || m_st == 2);
            chk(cur_req, "reg_on", reg_on, on_e);
            chk(cur_req, "bus_drv_en", bus_drv_en, on_e && vcc_above_low);
            chk(cur_req, "en_pd_strong", en_pd_strong, !on_e);
            chk(cur_req, "rst_req", rst_req, m_st == 1);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    initial begin
        cyc(3);
        chk("R1", "reset reg_on", reg_on, 1'b0);
        chk("R1", "reset pd", en_pd_strong, 1'b1);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", "off stays off", reg_on, 1'b0);

        cur_req = "R2"; batt_ok = 1'b1;
        cyc(1);
        chk("R2", "restart rst_req", rst_req, 1'b1);
        chk("R2", "restart reg_on", reg_on, 1'b1);
        cyc(1);
        chk("R2", "active no rst_req", rst_req, 1'b0);
        chk("R5", "active weak pd", en_pd_strong, 1'b0);

        cur_req = "R3";
        cyc(6);
        chk("R3", "early low en ignored", reg_on, 1'b1);

        cur_req = "R4"; en_pin = 1'b1;
        cyc(3);
        en_pin = 1'b0;
        cyc(1);
        chk("R4", "standby reg_on", reg_on, 1'b0);
        chk("R5", "standby strong pd", en_pd_strong, 1'b1);

        cur_req = "R6"; en_pin = 1'b1;
        cyc(1);
        chk("R6", "en wake", reg_on, 1'b1);
        cyc(2);
        en_pin = 1'b0;
        cyc(1);
        chk("R4", "second standby", reg_on, 1'b0);

        cur_req = "R7"; bus_rx = 1'b0;
        cyc(5);
        bus_rx = 1'b1;
        cyc(20);
        chk("R7", "glitch rejected", reg_on, 1'b0);
        bus_rx = 1'b0;
        cyc(30);
        chk("R7", "qualified wake", reg_on, 1'b1);
        bus_rx = 1'b1;
        cyc(5);
        chk("R3", "no disable after bus wake", reg_on, 1'b1);

        cur_req = "R10"; vcc_above_low = 1'b0;
        #0.5;
        chk("R10", "bus hiz low supply", bus_drv_en, 1'b0);
        cyc(1);
        vcc_above_low = 1'b1;
        #0.5;
        chk("R10", "bus on again", bus_drv_en, 1'b1);

        cur_req = "R8"; ot_trip = 1'b1;
        cyc(1);
        ot_trip = 1'b0;
        chk("R8", "thermal reg off", reg_on, 1'b0);
        chk("R8", "thermal bus off", bus_drv_en, 1'b0);
        cur_req = "R9"; en_pin = 1'b1; bus_rx = 1'b0;
        cyc(4);
        chk("R9", "en ignored in thermal", reg_on, 1'b0);
        en_pin = 1'b0;
        ot_recovered = 1'b1;
        cyc(1);
        ot_recovered = 1'b0;
        chk("R9", "recovery reset", rst_req, 1'b1);
        cyc(1);
        bus_rx = 1'b1;

        cur_req = "R12"; en_pin = 1'b1;
        cyc(2);
        en_pin = 1'b0; ot_trip = 1'b1;
        cyc(1);
        ot_trip = 1'b0;
        chk("R12", "trip beats standby request", en_pd_strong, 1'b1);
        ot_recovered = 1'b1;
        cyc(1);
        ot_recovered = 1'b0; en_pin = 1'b1;
        cyc(3);
        en_pin = 1'b0;
        cyc(2);
        en_pin = 1'b1; ot_trip = 1'b1;
        cyc(1);
        ot_trip = 1'b0; en_pin = 1'b0;
        chk("R12", "trip beats en wake", reg_on, 1'b0);
        ot_recovered = 1'b1;
        cyc(1);
        ot_recovered = 1'b0; en_pin = 1'b1;
        cyc(3);
        en_pin = 1'b0;
        cyc(2);
        bus_rx = 1'b0;
        while (!(m_st == 3 && m_cnt == N)) cyc(1);
        ot_trip = 1'b1;
        cyc(1);
        ot_trip = 1'b0; bus_rx = 1'b1;
        chk("R12", "trip beats bus wake", reg_on, 1'b0);

        cur_req = "R11"; ot_recovered = 1'b1;
        cyc(2);
        ot_recovered = 1'b0;
        chk("R11", "active before loss", reg_on, 1'b1);
        batt_ok = 1'b0;
        cyc(1);
        chk("R11", "battery loss off", reg_on, 1'b0);
        cyc(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule